// File: doc/BRIEF.md
# Two-Channel Indirect Register Bank

This block is the host side of a two-channel serial controller. Each channel has a control port and a data port. The host reaches most registers in two steps. First it writes a register number to the channel's control port. The next control-port access on that channel then reads or writes the chosen register. When the pointer is zero, a control-port write acts as the command register: its low nibble loads the pointer and its high nibble issues a one-cycle command to the channel logic. The transmit/receive data register can also be reached directly on the data port.

The block holds the write registers of both channels. It also holds:
- one master register shared by both channels, whose top two bits carry channel-reset and full-reset commands;
- the routing of address 7 to one of two registers, selected by bit 0 of register 15.

Read-back depends on the channel. Register 3 shows pending interrupts only on channel A. Register 2 shows the stored vector on channel A and a status-modified vector on channel B. An extended-read bit makes some read addresses mirror write registers. The block also flags accesses that come too close together. Status values, the receive byte, pending interrupts and the vector status code come from input ports.

Top module: `sio_regbank`

## Requirements
- R1: After reset every pointer is 0, every stored register is 0, and all pulses and flags are low. A control-port read with pointer 0 returns the channel's status-0 input.
- R2: On a channel whose pointer is nonzero, the next control-port access reads or writes register `ptr`. The pointer then returns to 0. Pointers are independent per channel.
- R3: A control-port write while the pointer is 0 loads the pointer from bits 3:0. When bits 7:4 are nonzero, it also pulses `cmd_valid` for one cycle with `cmd_code` equal to bits 7:4 and `cmd_chan` set to the channel (0 = A, 1 = B).
- R4: Register 8 can be reached through the data port or through pointer 8. A write pulses the channel's `tx_push` bit with `tx_byte`. A read returns that channel's byte of `rx_byte_in` and pulses its `rx_pop` bit.
- R5: A write to address 7 goes to the sync register (`cfg_sync`) when bit 0 of that channel's register 15 is 0. When the bit is 1, the write goes to the option register (`cfg_opt`) and the sync register is left unchanged.
- R6: Register 9 is shared by both channels and stores only bits 5:0 (`cfg_mic`). Bits 7:6 are commands: 00 none, 01 reset channel A, 10 reset channel B, 11 full reset. A channel reset pulses that bit of `chan_reset` and clears that channel's registers and option register. A full reset pulses both bits and `hw_reset` and also clears registers 2 and 9.
- R7: A write to register 14 stores only bits 4:0 (`cfg_dpll`). When bits 7:5 are nonzero, the write pulses `dpll_cmd_valid` with `dpll_cmd_code` equal to bits 7:5.
- R8: On channel A, read address 3 returns {2'b00, irq_pend}, where irq_pend bit 0 is B ext/status, bit 1 B tx, bit 2 B rx, bit 3 A ext/status, bit 4 A tx and bit 5 A rx. On channel B, read address 3 returns 0.
- R9: Register 2 is shared. Read address 2 returns it on channel A. On channel B it returns the same value, except that bits 3:1 are replaced by `vec_code` when bit 0 of register 9 is set.
- R10: When bit 6 of the channel's option register is 1, read addresses 4, 5, 9 and 11 return write registers 4, 5, 3 and 10; when the bit is 0 they return 0. Read addresses 12, 13 and 15 always return write registers 12, 13 and 15. Read addresses 6, 7 and 14 return 0.
- R11: `recov_viol` is high for one cycle after any access (either channel, either port) that begins fewer than REC_CYC (default 4) clock cycles after the previous access. The access is still carried out.
- R12: Read data appears on `rd_data` with `rd_valid` one cycle after the read access. Read addresses 1 and 10 return the channel's status-1 and status-10 inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle host access strobe |
| acc_chan | input | 1 | Channel of access (0 = A, 1 = B) |
| acc_data | input | 1 | 1 = data port, 0 = control port |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write byte |
| stat_rr0 | input | 16 | Status 0, channel A in [7:0], B in [15:8] |
| stat_rr1 | input | 16 | Status 1 per channel |
| stat_rr10 | input | 16 | Status 10 per channel |
| rx_byte_in | input | 16 | Received byte per channel |
| irq_pend | input | 6 | Pending interrupt bits |
| vec_code | input | 3 | Status code merged into the channel-B vector |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| recov_viol | output | 1 | Access recovery violation pulse |
| cmd_valid | output | 1 | Command-nibble pulse |
| cmd_chan | output | 1 | Channel of the command |
| cmd_code | output | 4 | Command nibble |
| tx_push | output | 2 | Transmit byte strobe per channel |
| tx_byte | output | 8 | Transmit byte |
| rx_pop | output | 2 | Receive byte consumed, per channel |
| dpll_cmd_valid | output | 1 | Register-14 command pulse |
| dpll_cmd_chan | output | 1 | Channel of register-14 command |
| dpll_cmd_code | output | 3 | Register-14 command code |
| chan_reset | output | 2 | Channel reset pulses |
| hw_reset | output | 1 | Full reset pulse |
| cfg_sync | output | 16 | Sync register per channel |
| cfg_opt | output | 16 | Option register per channel |
| cfg_dpll | output | 10 | Register-14 state bits per channel |
| cfg_mic | output | 6 | Stored bits of shared register 9 |

## Verification
The hardest states to reach are those where one register write changes how later accesses are decoded:
- bit 0 of register 15 redirects address 7;
- bit 6 of the option register switches the read mirrors on;
- bit 0 of register 9 changes channel B's vector;
- a reset command through register 9 clears one channel but not the other.

The stimulus builds each of these with full pointer-then-access write pairs. It then reads through both channels and checks that the unchanged channel still holds its values. Recovery timing is checked by issuing accesses with gaps of one, three and four cycles.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 4;
  localparam int unsigned NREG   = 1 << PTR_W;
  localparam int unsigned NCH    = 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PTR_W-1:0]  ptr_t;

  localparam ptr_t A_STAT0  = 4'd0;
  localparam ptr_t A_STAT1  = 4'd1;
  localparam ptr_t A_VEC    = 4'd2;
  localparam ptr_t A_PEND   = 4'd3;
  localparam ptr_t A_RXCFG  = 4'd3;
  localparam ptr_t A_MODE   = 4'd4;
  localparam ptr_t A_TXCFG  = 4'd5;
  localparam ptr_t A_SYNC   = 4'd7;
  localparam ptr_t A_DATA   = 4'd8;
  localparam ptr_t A_MASTER = 4'd9;
  localparam ptr_t A_STAT10 = 4'd10;
  localparam ptr_t A_MISC   = 4'd10;
  localparam ptr_t A_MIRROR = 4'd11;
  localparam ptr_t A_TCLO   = 4'd12;
  localparam ptr_t A_TCHI   = 4'd13;
  localparam ptr_t A_DPLL   = 4'd14;
  localparam ptr_t A_IEN    = 4'd15;

  localparam int unsigned OPT_EXT_BIT = 6;

  typedef enum logic [1:0] {
    RC_NONE = 2'b00,
    RC_CHA  = 2'b01,
    RC_CHB  = 2'b10,
    RC_ALL  = 2'b11
  } rst_cmd_e;
endpackage

// File: rtl/sio_gap.sv
module sio_gap #(
  parameter int unsigned REC_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  output logic viol
);
  localparam int unsigned CW = $clog2(REC_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(REC_CYC);

  logic [CW-1:0] since_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
      viol    <= 1'b0;
    end else begin
      viol <= acc && seen_q && (since_q < LIMIT);
      if (acc) begin
        since_q <= CW'(1);
        seen_q  <= 1'b1;
      end else if (since_q < LIMIT) begin
        since_q <= since_q + CW'(1);
      end
    end
  end

  AST_VIOL_NEEDS_ACC: assert property (@(posedge clk) disable iff (rst)
    viol |-> $past(acc)); // R11
  AST_NO_VIOL_FIRST: assert property (@(posedge clk) disable iff (rst)
    (acc && !seen_q) |=> !viol); // R11
endmodule

// File: rtl/sio_common.sv
module sio_common
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vec_we,
  input  logic       mst_we,
  input  byte_t      wdata,
  output byte_t      vec_q,
  output logic [5:0] mst_q,
  output logic       clr_a,
  output logic       clr_b,
  output logic       clr_all
);
  rst_cmd_e cmd;
  assign cmd = rst_cmd_e'(wdata[7:6]);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q   <= '0;
      mst_q   <= '0;
      clr_a   <= 1'b0;
      clr_b   <= 1'b0;
      clr_all <= 1'b0;
    end else begin
      clr_a   <= 1'b0;
      clr_b   <= 1'b0;
      clr_all <= 1'b0;
      if (vec_we) vec_q <= wdata;
      if (mst_we) begin
        case (cmd)
          RC_ALL: begin
            vec_q   <= '0;
            mst_q   <= '0;
            clr_a   <= 1'b1;
            clr_b   <= 1'b1;
            clr_all <= 1'b1;
          end
          RC_CHA: begin
            mst_q <= wdata[5:0];
            clr_a <= 1'b1;
          end
          RC_CHB: begin
            mst_q <= wdata[5:0];
            clr_b <= 1'b1;
          end
          default: mst_q <= wdata[5:0];
        endcase
      end
    end
  end

  AST_FULL_CLEARS_MASTER: assert property (@(posedge clk) disable iff (rst)
    (mst_we && wdata[7:6] == 2'b11) |=> (mst_q == 6'd0 && vec_q == 8'd0)); // R6
  AST_CHAN_CMD_STORES: assert property (@(posedge clk) disable iff (rst)
    (mst_we && wdata[7:6] != 2'b11) |=> (mst_q == $past(wdata[5:0]))); // R6
  AST_ALL_IMPLIES_BOTH: assert property (@(posedge clk) disable iff (rst)
    clr_all |-> (clr_a && clr_b)); // R6
endmodule

// File: rtl/sio_chan.sv
module sio_chan
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       acc_ctl,
  input  logic       acc_dat,
  input  logic       acc_wr,
  input  byte_t      wdata,
  input  byte_t      st0,
  input  byte_t      st1,
  input  byte_t      st10,
  input  byte_t      rxd,
  input  byte_t      rr2_v,
  input  byte_t      rr3_v,
  output byte_t      rd_byte,
  output logic       vec_we,
  output logic       mst_we,
  output logic       tx_push,
  output byte_t      tx_byte,
  output logic       rx_pop,
  output logic       cmd_v,
  output logic [3:0] cmd_code,
  output logic       dcmd_v,
  output logic [2:0] dcmd_code,
  output byte_t      cfg_sync,
  output byte_t      cfg_opt,
  output logic [4:0] cfg_dpll
);
  ptr_t  ptr_q;
  byte_t wreg [NREG];
  byte_t opt_q;
  ptr_t  sel;
  logic  ext;
  logic  reg_wr;

  assign sel    = acc_dat ? A_DATA : ptr_q;
  assign ext    = opt_q[OPT_EXT_BIT];
  assign reg_wr = acc_ctl && acc_wr && (ptr_q != '0);
  assign vec_we = reg_wr && (ptr_q == A_VEC);
  assign mst_we = reg_wr && (ptr_q == A_MASTER);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr_q     <= '0;
      opt_q     <= '0;
      tx_push   <= 1'b0;
      tx_byte   <= '0;
      rx_pop    <= 1'b0;
      cmd_v     <= 1'b0;
      cmd_code  <= '0;
      dcmd_v    <= 1'b0;
      dcmd_code <= '0;
      for (int i = 0; i < NREG; i++) wreg[i] <= '0;
    end else begin
      tx_push <= 1'b0;
      rx_pop  <= 1'b0;
      cmd_v   <= 1'b0;
      dcmd_v  <= 1'b0;
      if (acc_ctl) begin
        if (ptr_q == '0) begin
          if (acc_wr) begin
            ptr_q    <= wdata[3:0];
            cmd_v    <= |wdata[7:4];
            cmd_code <= wdata[7:4];
          end
        end else begin
          ptr_q <= '0;
          if (acc_wr) begin
            case (ptr_q)
              A_SYNC: begin
                if (wreg[A_IEN][0]) opt_q <= wdata;
                else                wreg[A_SYNC] <= wdata;
              end
              A_DATA: begin
                tx_push <= 1'b1;
                tx_byte <= wdata;
              end
              A_DPLL: begin
                wreg[A_DPLL] <= {3'b000, wdata[4:0]};
                dcmd_v       <= |wdata[7:5];
                dcmd_code    <= wdata[7:5];
              end
              A_VEC, A_MASTER: ;
              default: wreg[ptr_q] <= wdata;
            endcase
          end else if (ptr_q == A_DATA) begin
            rx_pop <= 1'b1;
          end
        end
      end else if (acc_dat) begin
        if (acc_wr) begin
          tx_push <= 1'b1;
          tx_byte <= wdata;
        end else begin
          rx_pop <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    case (sel)
      A_STAT0:  rd_byte = st0;
      A_STAT1:  rd_byte = st1;
      A_VEC:    rd_byte = rr2_v;
      A_PEND:   rd_byte = rr3_v;
      A_MODE:   rd_byte = ext ? wreg[A_MODE]  : '0;
      A_TXCFG:  rd_byte = ext ? wreg[A_TXCFG] : '0;
      A_DATA:   rd_byte = rxd;
      A_MASTER: rd_byte = ext ? wreg[A_RXCFG] : '0;
      A_STAT10: rd_byte = st10;
      A_MIRROR: rd_byte = ext ? wreg[A_MISC]  : '0;
      A_TCLO:   rd_byte = wreg[A_TCLO];
      A_TCHI:   rd_byte = wreg[A_TCHI];
      A_IEN:    rd_byte = wreg[A_IEN];
      default:  rd_byte = '0;
    endcase
  end

  assign cfg_sync = wreg[A_SYNC];
  assign cfg_opt  = opt_q;
  assign cfg_dpll = wreg[A_DPLL][4:0];

  AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (acc_ctl && ptr_q != '0) |=> (ptr_q == '0)); // R2
  AST_PTR_LOADS: assert property (@(posedge clk) disable iff (rst)
    (acc_ctl && acc_wr && ptr_q == '0 && !clr) |=> (ptr_q == $past(wdata[3:0]))); // R3
  AST_OPT_KEEPS_SYNC: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && ptr_q == A_SYNC && wreg[A_IEN][0] && !clr) |=> $stable(cfg_sync)); // R5
  AST_DPLL_STATE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && ptr_q == A_DPLL && !clr) |=> (cfg_dpll == $past(wdata[4:0]))); // R7
  AST_DATA_PORT_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (acc_dat && !acc_ctl && !clr) |=> $stable(ptr_q)); // R4
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_pkg::*;
#(
  parameter int unsigned REC_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_valid,
  input  logic        acc_chan,
  input  logic        acc_data,
  input  logic        acc_wr,
  input  logic [7:0]  acc_wdata,
  input  logic [15:0] stat_rr0,
  input  logic [15:0] stat_rr1,
  input  logic [15:0] stat_rr10,
  input  logic [15:0] rx_byte_in,
  input  logic [5:0]  irq_pend,
  input  logic [2:0]  vec_code,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        recov_viol,
  output logic        cmd_valid,
  output logic        cmd_chan,
  output logic [3:0]  cmd_code,
  output logic [1:0]  tx_push,
  output logic [7:0]  tx_byte,
  output logic [1:0]  rx_pop,
  output logic        dpll_cmd_valid,
  output logic        dpll_cmd_chan,
  output logic [2:0]  dpll_cmd_code,
  output logic [1:0]  chan_reset,
  output logic        hw_reset,
  output logic [15:0] cfg_sync,
  output logic [15:0] cfg_opt,
  output logic [9:0]  cfg_dpll,
  output logic [5:0]  cfg_mic
);
  byte_t       rdb      [NCH];
  byte_t       txb      [NCH];
  byte_t       rr2      [NCH];
  byte_t       rr3      [NCH];
  logic [3:0]  cc       [NCH];
  logic [2:0]  dc       [NCH];
  logic [NCH-1:0] vec_we, mst_we, cmd_v, dcmd_v, clr;
  byte_t       vec_q;
  logic [5:0]  mst_q;
  logic        clr_a, clr_b, clr_all;

  sio_gap #(.REC_CYC(REC_CYC)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .acc  (acc_valid),
    .viol (recov_viol)
  );

  sio_common u_common (
    .clk     (clk),
    .rst     (rst),
    .vec_we  (|vec_we),
    .mst_we  (|mst_we),
    .wdata   (acc_wdata),
    .vec_q   (vec_q),
    .mst_q   (mst_q),
    .clr_a   (clr_a),
    .clr_b   (clr_b),
    .clr_all (clr_all)
  );

  assign clr = {clr_b, clr_a};

  assign rr2[0] = vec_q;
  assign rr2[1] = mst_q[0] ? {vec_q[7:4], vec_code, vec_q[0]} : vec_q;
  assign rr3[0] = {2'b00, irq_pend};
  assign rr3[1] = '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_c;
    assign sel_c = acc_valid && (acc_chan == c[0]);

    sio_chan u_chan (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr[c]),
      .acc_ctl   (sel_c && !acc_data),
      .acc_dat   (sel_c && acc_data),
      .acc_wr    (acc_wr),
      .wdata     (acc_wdata),
      .st0       (stat_rr0[c*8 +: 8]),
      .st1       (stat_rr1[c*8 +: 8]),
      .st10      (stat_rr10[c*8 +: 8]),
      .rxd       (rx_byte_in[c*8 +: 8]),
      .rr2_v     (rr2[c]),
      .rr3_v     (rr3[c]),
      .rd_byte   (rdb[c]),
      .vec_we    (vec_we[c]),
      .mst_we    (mst_we[c]),
      .tx_push   (tx_push[c]),
      .tx_byte   (txb[c]),
      .rx_pop    (rx_pop[c]),
      .cmd_v     (cmd_v[c]),
      .cmd_code  (cc[c]),
      .dcmd_v    (dcmd_v[c]),
      .dcmd_code (dc[c]),
      .cfg_sync  (cfg_sync[c*8 +: 8]),
      .cfg_opt   (cfg_opt[c*8 +: 8]),
      .cfg_dpll  (cfg_dpll[c*5 +: 5])
    );
  end

  assign tx_byte        = tx_push[1] ? txb[1] : txb[0];
  assign cmd_valid      = |cmd_v;
  assign cmd_chan       = cmd_v[1];
  assign cmd_code       = cmd_v[1] ? cc[1] : cc[0];
  assign dpll_cmd_valid = |dcmd_v;
  assign dpll_cmd_chan  = dcmd_v[1];
  assign dpll_cmd_code  = dcmd_v[1] ? dc[1] : dc[0];
  assign chan_reset     = clr;
  assign hw_reset       = clr_all;
  assign cfg_mic        = mst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_wr;
      if (acc_valid && !acc_wr) rd_data <= acc_chan ? rdb[1] : rdb[0];
    end
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_wr)); // R12
  AST_TX_ONE_CHAN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_push)); // R4
  AST_TX_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|tx_push) |-> $past(acc_valid && acc_wr)); // R4
endmodule

// File: tb/sio_regbank_tb.sv
module sio_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_chan = 1'b0, acc_data = 1'b0, acc_wr = 1'b0;
  logic [7:0]  acc_wdata = '0;
  logic [15:0] stat_rr0 = 16'hB1A0, stat_rr1 = 16'hC2D3, stat_rr10 = 16'h1E0F;
  logic [15:0] rx_byte_in = 16'h6655;
  logic [5:0]  irq_pend = 6'h2A;
  logic [2:0]  vec_code = 3'd5;
  logic        rd_valid, recov_viol, cmd_valid, cmd_chan, dpll_cmd_valid, dpll_cmd_chan, hw_reset;
  logic [7:0]  rd_data, tx_byte;
  logic [3:0]  cmd_code;
  logic [1:0]  tx_push, rx_pop, chan_reset;
  logic [2:0]  dpll_cmd_code;
  logic [15:0] cfg_sync, cfg_opt;
  logic [9:0]  cfg_dpll;
  logic [5:0]  cfg_mic;

  always #5 clk = ~clk;

  sio_regbank u_dut (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] expq [$];
  string      tagq [$];

  logic       s_viol, s_cmdv, s_cmdch, s_dv, s_dch, s_hw;
  logic [3:0] s_cmdc;
  logic [2:0] s_dc;
  logic [1:0] s_tx, s_rx, s_crst;
  logic [7:0] s_txb;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (expq.size() == 0) chk("R12 unexpected read", 32'(rd_data), 32'hFFFF_FFFF);
      else begin
        logic [7:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(t, 32'(rd_data), 32'(e));
      end
    end
  end

  task automatic acc(input bit ch, input bit dat, input bit wr, input logic [7:0] wd, input int idle);
    acc_valid = 1'b1; acc_chan = ch; acc_data = dat; acc_wr = wr; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0;
    s_viol = recov_viol; s_cmdv = cmd_valid; s_cmdch = cmd_chan; s_cmdc = cmd_code;
    s_dv = dpll_cmd_valid; s_dch = dpll_cmd_chan; s_dc = dpll_cmd_code;
    s_tx = tx_push; s_txb = tx_byte; s_rx = rx_pop; s_crst = chan_reset; s_hw = hw_reset;
    repeat (idle) @(negedge clk);
  endtask

  task automatic rd_expect(input bit ch, input bit dat, input logic [7:0] e, input string tag, input int idle);
    expq.push_back(e);
    tagq.push_back(tag);
    acc(ch, dat, 1'b0, 8'h00, idle);
  endtask

  task automatic wreg(input bit ch, input logic [3:0] a, input logic [7:0] v);
    acc(ch, 1'b0, 1'b1, {4'h0, a}, 3);
    acc(ch, 1'b0, 1'b1, v, 3);
  endtask

  task automatic rreg(input bit ch, input logic [3:0] a, input logic [7:0] e, input string tag);
    acc(ch, 1'b0, 1'b1, {4'h0, a}, 3);
    rd_expect(ch, 1'b0, e, tag, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_sync", 32'(cfg_sync), 0);
    chk("R1 cfg_mic", 32'(cfg_mic), 0);
    chk("R1 pulses", 32'({recov_viol, chan_reset, hw_reset, tx_push}), 0);
    rd_expect(0, 0, 8'hA0, "R1 idle read A", 3);
    chk("R11 first access no flag", 32'(s_viol), 0);
    rd_expect(1, 0, 8'hB1, "R1 idle read B", 3);

    // R2 pointer access, then return to 0
    wreg(0, 4'd12, 8'h5A);
    rreg(0, 4'd12, 8'h5A, "R2 read WR12 A");
    rd_expect(0, 0, 8'hA0, "R2 pointer back to 0", 3);
    rreg(1, 4'd12, 8'h00, "R2 channel B independent");

    // R3 command nibble
    acc(1, 0, 1, 8'h30, 3);
    chk("R3 cmd pulse", 32'({s_cmdv, s_cmdch, s_cmdc}), 32'({1'b1, 1'b1, 4'h3}));
    rd_expect(1, 0, 8'hB1, "R3 pointer stays 0", 3);
    acc(1, 0, 1, 8'h5C, 3);
    chk("R3 cmd 5", 32'({s_cmdv, s_cmdc}), 32'({1'b1, 4'h5}));
    acc(1, 0, 1, 8'h3B, 3);
    chk("R3 no cmd on reg write", 32'(s_cmdv), 0);
    rreg(1, 4'd12, 8'h3B, "R3 pointer from nibble");

    // R4 data register
    acc(0, 1, 1, 8'hA5, 3);
    chk("R4 data port tx", 32'({s_tx, s_txb}), 32'({2'b01, 8'hA5}));
    wreg(1, 4'd8, 8'h11);
    chk("R4 pointer-8 tx", 32'({s_tx, s_txb}), 32'({2'b10, 8'h11}));
    rd_expect(0, 1, 8'h55, "R4 data port rx A", 3);
    chk("R4 rx_pop A", 32'(s_rx), 32'(2'b01));
    rreg(1, 4'd8, 8'h66, "R4 pointer-8 rx B");
    chk("R4 rx_pop B", 32'(s_rx), 32'(2'b10));

    // R5 address 7 routing
    wreg(0, 4'd7, 8'h7E);
    chk("R5 sync write", 32'(cfg_sync[7:0]), 32'h7E);
    wreg(0, 4'd15, 8'h01);
    wreg(0, 4'd7, 8'h40);
    chk("R5 option write", 32'(cfg_opt[7:0]), 32'h40);
    chk("R5 sync unchanged", 32'(cfg_sync[7:0]), 32'h7E);

    // R10 extended read-back
    wreg(0, 4'd4, 8'h44);
    wreg(0, 4'd5, 8'h55);
    wreg(0, 4'd3, 8'h33);
    wreg(0, 4'd10, 8'hAA);
    rreg(0, 4'd4, 8'h44, "R10 RR4 mirror");
    rreg(0, 4'd5, 8'h55, "R10 RR5 mirror");
    rreg(0, 4'd9, 8'h33, "R10 RR9 mirror");
    rreg(0, 4'd11, 8'hAA, "R10 RR11 mirror");
    rreg(0, 4'd15, 8'h01, "R10 RR15 echo");
    wreg(0, 4'd14, 8'h0C);
    rreg(0, 4'd14, 8'h00, "R10 RR14 zero");
    wreg(1, 4'd4, 8'h99);
    rreg(1, 4'd4, 8'h00, "R10 no mirror when ext clear");

    // R8 pending interrupts
    rreg(0, 4'd3, 8'h2A, "R8 RR3 on A");
    rreg(1, 4'd3, 8'h00, "R8 RR3 on B");

    // R9 vector
    wreg(1, 4'd2, 8'hC3);
    rreg(0, 4'd2, 8'hC3, "R9 RR2 on A");
    rreg(1, 4'd2, 8'hC3, "R9 RR2 B plain");
    wreg(0, 4'd9, 8'h01);
    chk("R6 shared master", 32'(cfg_mic), 32'h01);
    rreg(1, 4'd2, 8'hCB, "R9 RR2 B with status");

    // R7 register 14
    wreg(0, 4'd14, 8'hFF);
    chk("R7 dpll state", 32'(cfg_dpll[4:0]), 32'h1F);
    chk("R7 dpll cmd", 32'({s_dv, s_dch, s_dc}), 32'({1'b1, 1'b0, 3'd7}));

    // R6 channel A reset from channel B
    wreg(1, 4'd9, 8'h41);
    chk("R6 chan A reset pulse", 32'({s_crst, s_hw}), 32'({2'b01, 1'b0}));
    chk("R6 only low bits stored", 32'(cfg_mic), 32'h01);
    chk("R6 A option cleared", 32'(cfg_opt[7:0]), 0);
    rreg(0, 4'd12, 8'h00, "R6 A cleared");
    rreg(1, 4'd12, 8'h3B, "R6 B kept");

    // R6 full reset
    wreg(0, 4'd9, 8'hC5);
    chk("R6 full reset pulses", 32'({s_crst, s_hw}), 32'({2'b11, 1'b1}));
    chk("R6 master cleared", 32'(cfg_mic), 0);
    rreg(1, 4'd12, 8'h00, "R6 B cleared");
    rreg(0, 4'd2, 8'h00, "R6 vector cleared");

    // R11 recovery timing
    rd_expect(0, 0, 8'hA0, "R11 ok read", 0);
    chk("R11 gap 4 no flag", 32'(s_viol), 0);
    rd_expect(1, 0, 8'hB1, "R11 gap 1 still done", 2);
    chk("R11 gap 1 flag", 32'(s_viol), 1);
    rd_expect(0, 0, 8'hA0, "R11 gap 3 read", 3);
    chk("R11 gap 3 flag", 32'(s_viol), 1);
    rd_expect(0, 0, 8'hA0, "R11 gap 4 read", 3);
    chk("R11 gap 4 clear", 32'(s_viol), 0);

    // R12 status reads
    rreg(0, 4'd1, 8'hD3, "R12 RR1 A");
    rreg(1, 4'd10, 8'h1E, "R12 RR10 B");

    repeat (4) @(negedge clk);
    chk("R12 all reads returned", 32'(expq.size()), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule